// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that moves a small 8-bit CPU into and out of interrupt handlers. When a request line is pending, interrupts are globally enabled and the core signals that an instruction has just completed, the sequencer takes the request. It stores the 16-bit return address on a byte-wide stack that grows downward, clears the global enable and loads the handler's vector address into the program counter. The whole entry takes four cycles after the request is taken.

When the core executes a return-from-interrupt, the sequencer reads the two return-address bytes back in reverse order and restores the program counter. The stack pointer rises by two and the global enable is set again, also in four cycles. The first instruction boundary after a return never takes a request, so exactly one instruction of the interrupted program runs first. The status register is left to software. The sequencer owns the stack pointer and the global enable bit, and the core can write that bit only while the sequencer is idle.

Top module: `irq_seq_top`

## Requirements
- R1: A request is taken only in an idle cycle with instrDone high, gie high and at least one irqReq bit set. A request held during a multi-cycle instruction (instrDone low) is not taken until the boundary.
- R2: After the cycle in which a request is taken, the sequence runs four cycles and pcLoad is high in the fourth of them.
- R3: In the first entry cycle the low return byte is written to address sp. In the second the high byte is written to sp-1. sp ends two lower. stkWe and stkRe are never high together.
- R4: The lowest-numbered pending source wins. pcOut equals twice its index during the vector load, and irqAck is one-hot at that index in that cycle only.
- R5: gie is cleared in the cycle after a request is taken, and no request is taken while gie is low.
- R6: A retiReq in an idle cycle starts a return. Cycles 1 and 2 read sp+1 with stkRe high, and sp rises by one in each. stkRdata is taken one cycle after each read, with the first read giving the high byte. In cycle 4 pcLoad is high with pcOut equal to {high, low}, and gie is 1 from the next cycle.
- R7: After a return, the next instrDone cycle never takes a request. The instrDone cycle after that one can.
- R8: gieWr loads gieVal into gie in idle cycles that take no request and no return. It has no effect while busy.
- R9: busy is high in exactly the four entry cycles and the four return cycles.
- R10: After reset sp equals SpInit, gie is 0 and pcLoad, stkWe, stkRe, irqAck and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irqReq | input | NumSrc | Pending request lines, bit i is source i |
| instrDone | input | 1 | Current instruction completes this cycle |
| retiReq | input | 1 | Return-from-interrupt instruction is executing |
| pcIn | input | AddrW | Return address to save |
| gieWr | input | 1 | Write strobe for the global enable |
| gieVal | input | 1 | Value for the global enable write |
| stkRdata | input | 8 | Stack read data, one cycle after stkRe |
| stkWe | output | 1 | Stack write strobe |
| stkRe | output | 1 | Stack read strobe |
| stkAddr | output | AddrW | Stack address |
| stkWdata | output | 8 | Stack write data |
| sp | output | AddrW | Stack pointer |
| pcLoad | output | 1 | Program counter load strobe |
| pcOut | output | AddrW | Program counter load value |
| gie | output | 1 | Global interrupt enable |
| irqAck | output | NumSrc | One-hot acknowledge of the served source |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
A wrong sequencer state shows up at the stack port, on busy or on pcLoad within one cycle. Write strobes or addresses come out shifted, the sequence runs too long or too short, or the load lands in the wrong slot. Errors in the captured address or the winning index stay hidden until the store or the vector load, at most four cycles later. A wrong blocking flag after a return shows only at the next instruction boundary, when a request is taken too early or not at all. A byte-order error shows only at the end of a full return, as a wrong restored address.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    SqIdle, SqEnt1, SqEnt2, SqEnt3, SqEnt4,
    SqRet1, SqRet2, SqRet3, SqRet4
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic pushLo;
    logic pushHi;
    logic popHi;
    logic popLo;
    logic latchHi;
    logic latchLo;
    logic loadVec;
    logic loadRet;
  } seqStrobes_t;

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter int IdxW   = (NumSrc > 1) ? $clog2(NumSrc) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NumSrc-1:0] irqReq,
  input  logic              instrDone,
  input  logic              retiReq,
  input  logic              gieWr,
  input  logic              gieVal,
  output logic [IdxW-1:0]   winIdx,
  output seqStrobes_t       st,
  output logic              gie,
  output logic              busy
);

  seqState_t state, stateNxt;
  logic blockOne;
  logic accept, startRet;

  // Lowest index wins: scan from the top down so the last hit is the smallest.
  always_comb begin
    winIdx = '0;
    for (int i = NumSrc - 1; i >= 0; i--) begin
      if (irqReq[i]) winIdx = IdxW'(i);
    end
  end

  assign startRet = (state == SqIdle) && retiReq;
  assign accept   = (state == SqIdle) && !retiReq && instrDone && gie &&
                    !blockOne && (|irqReq);

  always_comb begin
    stateNxt = state;
    unique case (state)
      SqIdle: begin
        if (startRet)    stateNxt = SqRet1;
        else if (accept) stateNxt = SqEnt1;
      end
      SqEnt1:  stateNxt = SqEnt2;
      SqEnt2:  stateNxt = SqEnt3;
      SqEnt3:  stateNxt = SqEnt4;
      SqEnt4:  stateNxt = SqIdle;
      SqRet1:  stateNxt = SqRet2;
      SqRet2:  stateNxt = SqRet3;
      SqRet3:  stateNxt = SqRet4;
      SqRet4:  stateNxt = SqIdle;
      default: stateNxt = SqIdle;
    endcase
  end

  always_comb begin
    st         = '0;
    st.capture = accept;
    st.pushLo  = (state == SqEnt1);
    st.pushHi  = (state == SqEnt2);
    st.loadVec = (state == SqEnt4);
    st.popHi   = (state == SqRet1);
    st.popLo   = (state == SqRet2);
    st.latchHi = (state == SqRet2);
    st.latchLo = (state == SqRet3);
    st.loadRet = (state == SqRet4);
  end

  assign busy = (state != SqIdle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SqIdle;
      gie      <= 1'b0;
      blockOne <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        gie <= 1'b0;
      end else if (state == SqRet4) begin
        gie      <= 1'b1;
        blockOne <= 1'b1;
      end else if (state == SqIdle && !startRet) begin
        if (gieWr) gie <= gieVal;
        if (instrDone) blockOne <= 1'b0;
      end
    end
  end

  // R5
  gie_low_at_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SqEnt4) |-> !gie);

  // R6
  gie_set_after_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SqRet4) |=> gie);

  // R7
  one_instr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SqRet4) |=> !accept);

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int              NumSrc = 8,
  parameter int              AddrW  = 16,
  parameter logic [AddrW-1:0] SpInit = 16'h025F,
  parameter int              IdxW   = (NumSrc > 1) ? $clog2(NumSrc) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       st,
  input  logic [IdxW-1:0]   winIdx,
  input  logic [AddrW-1:0]  pcIn,
  input  logic [7:0]        stkRdata,
  output logic [AddrW-1:0]  sp,
  output logic              stkWe,
  output logic              stkRe,
  output logic [AddrW-1:0]  stkAddr,
  output logic [7:0]        stkWdata,
  output logic              pcLoad,
  output logic [AddrW-1:0]  pcOut,
  output logic [NumSrc-1:0] irqAck
);

  localparam int PadW = AddrW - IdxW - 1;

  logic [AddrW-1:0] retPc;
  logic [IdxW-1:0]  vecIdx;
  logic [7:0]       hiByte, loByte;
  logic [AddrW-1:0] spUp;

  assign spUp = sp + AddrW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp     <= SpInit;
      retPc  <= '0;
      vecIdx <= '0;
      hiByte <= '0;
      loByte <= '0;
    end else begin
      if (st.capture) begin
        retPc  <= pcIn;
        vecIdx <= winIdx;
      end
      if (st.pushLo || st.pushHi)    sp <= sp - AddrW'(1);
      else if (st.popHi || st.popLo) sp <= spUp;
      if (st.latchHi) hiByte <= stkRdata;
      if (st.latchLo) loByte <= stkRdata;
    end
  end

  assign stkWe    = st.pushLo | st.pushHi;
  assign stkRe    = st.popHi | st.popLo;
  assign stkAddr  = stkWe ? sp : spUp;
  assign stkWdata = st.pushLo ? retPc[7:0] : retPc[15:8];
  assign pcLoad   = st.loadVec | st.loadRet;
  assign pcOut    = st.loadVec ? {{PadW{1'b0}}, vecIdx, 1'b0}
                               : {{(AddrW-16){1'b0}}, hiByte, loByte};

  for (genvar g = 0; g < NumSrc; g++) begin : gAck
    assign irqAck[g] = st.loadVec && (vecIdx == IdxW'(g));
  end

  // R4
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irqAck));

  // R3
  no_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stkWe && stkRe));

  // R3
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.pushHi |-> (stkAddr == $past(stkAddr) - AddrW'(1)));

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int              NumSrc = 8,
  parameter int              AddrW  = 16,
  parameter logic [AddrW-1:0] SpInit = 16'h025F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NumSrc-1:0] irqReq,
  input  logic              instrDone,
  input  logic              retiReq,
  input  logic [AddrW-1:0]  pcIn,
  input  logic              gieWr,
  input  logic              gieVal,
  input  logic [7:0]        stkRdata,
  output logic              stkWe,
  output logic              stkRe,
  output logic [AddrW-1:0]  stkAddr,
  output logic [7:0]        stkWdata,
  output logic [AddrW-1:0]  sp,
  output logic              pcLoad,
  output logic [AddrW-1:0]  pcOut,
  output logic              gie,
  output logic [NumSrc-1:0] irqAck,
  output logic              busy
);

  localparam int IdxW = (NumSrc > 1) ? $clog2(NumSrc) : 1;

  seqStrobes_t     strobes;
  logic [IdxW-1:0] winIdx;

  irq_seq_ctrl #(.NumSrc(NumSrc), .IdxW(IdxW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .instrDone(instrDone),
    .retiReq(retiReq), .gieWr(gieWr), .gieVal(gieVal),
    .winIdx(winIdx), .st(strobes), .gie(gie), .busy(busy)
  );

  irq_seq_dp #(.NumSrc(NumSrc), .AddrW(AddrW), .SpInit(SpInit), .IdxW(IdxW)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(strobes), .winIdx(winIdx), .pcIn(pcIn),
    .stkRdata(stkRdata), .sp(sp), .stkWe(stkWe), .stkRe(stkRe),
    .stkAddr(stkAddr), .stkWdata(stkWdata), .pcLoad(pcLoad), .pcOut(pcOut),
    .irqAck(irqAck)
  );

endmodule

// File: tb/sim_irq_seq_top.sv
`timescale 1ns/1ps
module sim_irq_seq_top;

  localparam int NumSrc = 8;
  localparam logic [15:0] SpInit = 16'h025F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NumSrc-1:0] irqReq = '0;
  logic instrDone = 1'b0, retiReq = 1'b0, gieWr = 1'b0, gieVal = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  stkRdata = '0;
  logic stkWe, stkRe, pcLoad, gie, busy;
  logic [15:0] stkAddr, sp, pcOut;
  logic [7:0]  stkWdata;
  logic [NumSrc-1:0] irqAck;

  always #2.5 clk = ~clk;

  irq_seq_top #(.NumSrc(NumSrc), .AddrW(16), .SpInit(SpInit)) u0 (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .instrDone(instrDone),
    .retiReq(retiReq), .pcIn(pcIn), .gieWr(gieWr), .gieVal(gieVal),
    .stkRdata(stkRdata), .stkWe(stkWe), .stkRe(stkRe), .stkAddr(stkAddr),
    .stkWdata(stkWdata), .sp(sp), .pcLoad(pcLoad), .pcOut(pcOut),
    .gie(gie), .irqAck(irqAck), .busy(busy)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference state
  int phase = 0;
  int spM = SpInit, idxM = 0;
  bit gieM = 0, blockM = 0;
  int retPcM = 0, hiM = 0, loM = 0;
  logic [7:0] mem [int];
  logic [7:0] rdPend = '0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (phase %0d)", tag, act, exp, phase);
    end
  endtask

  task automatic tick();
    bit eWe, eRe, ePl;
    int eAddr, eData, ePc, eAck;
    eWe = (phase == 1 || phase == 2);
    eRe = (phase == 11 || phase == 12);
    eAddr = eWe ? spM : ((spM + 1) & 16'hFFFF);
    eData = (phase == 1) ? (retPcM & 8'hFF) : ((retPcM >> 8) & 8'hFF);
    ePl = (phase == 4 || phase == 14);
    ePc = (phase == 4) ? idxM * 2 : ((hiM << 8) | loM);
    eAck = (phase == 4) ? (1 << idxM) : 0;
    chk("R3 stkWe", stkWe, eWe);
    chk("R6 stkRe", stkRe, eRe);
    if (eWe || eRe) chk("R3/R6 stkAddr", stkAddr, eAddr);
    if (eWe) chk("R3 stkWdata", stkWdata, eData);
    chk("R2 pcLoad", pcLoad, ePl);
    if (ePl) chk((phase == 4) ? "R4 pcOut" : "R6 pcOut", pcOut, ePc);
    chk("R4 irqAck", irqAck, eAck);
    chk("R5 gie", gie, gieM);
    chk("R3 sp", sp, spM);
    chk("R9 busy", busy, phase != 0);
    // stack memory driven by the block's own strobes
    if (stkWe) mem[int'(stkAddr)] = stkWdata;
    if (stkRe) rdPend = mem.exists(int'(stkAddr)) ? mem[int'(stkAddr)] : 8'h00;
    // advance reference
    case (phase)
      0: begin
        if (retiReq) phase = 11;
        else if (instrDone && gieM && !blockM && (irqReq != 0)) begin
          retPcM = pcIn;
          idxM = 0;
          for (int i = NumSrc - 1; i >= 0; i--) if (irqReq[i]) idxM = i;
          gieM = 0;
          phase = 1;
        end else begin
          if (gieWr) gieM = gieVal;
          if (instrDone) blockM = 0;
        end
      end
      1, 2: begin spM = (spM - 1) & 16'hFFFF; phase++; end
      3: phase = 4;
      4: phase = 0;
      11: begin hiM = mem[(spM + 1) & 16'hFFFF]; spM = (spM + 1) & 16'hFFFF; phase = 12; end
      12: begin loM = mem[(spM + 1) & 16'hFFFF]; spM = (spM + 1) & 16'hFFFF; phase = 13; end
      13: phase = 14;
      14: begin gieM = 1; blockM = 1; phase = 0; end
      default: phase = 0;
    endcase
    @(negedge clk);
    stkRdata = rdPend;
    instrDone = 0; retiReq = 0; gieWr = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic boundary();
    instrDone = 1;
    tick();
  endtask

  task automatic ret();
    retiReq = 1;
    tick();
    idle(4);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 sp", sp, SpInit);
    chk("R10 gie", gie, 0);
    chk("R10 strobes", {pcLoad, stkWe, stkRe, busy, irqAck}, 0);
    rst_n = 1;
    @(negedge clk);
    idle(2);
    // R5: request with gie low is not taken
    irqReq = 8'b0010_1000;
    pcIn = 16'h1234;
    boundary();
    chk("R5 no entry while gie low", busy, 0);
    // R8: enable
    gieWr = 1; gieVal = 1;
    tick();
    chk("R8 gie written", gie, 1);
    // R1: multi-cycle instruction, no boundary for several cycles
    idle(3);
    chk("R1 waits for boundary", busy, 0);
    boundary();
    chk("R2 busy after accept", busy, 1);
    // R8: write while busy ignored
    gieWr = 1; gieVal = 1;
    tick();
    idle(3);
    chk("R8 gie unchanged by busy write", gie, 0);
    chk("R3 low byte at SpInit", mem[SpInit], 8'h34);
    chk("R3 high byte below", mem[SpInit - 1], 8'h12);
    // R5: boundaries in handler do not nest
    boundary(); boundary();
    chk("R5 no nesting", busy, 0);
    // return, then R7
    irqReq = 8'b0010_0000;
    pcIn = 16'hBEEF;
    ret();
    chk("R6 sp restored", sp, SpInit);
    boundary();
    chk("R7 first boundary blocked", busy, 0);
    boundary();
    chk("R7 second boundary taken", busy, 1);
    idle(5);
    // nested entry with software enable in handler
    gieWr = 1; gieVal = 1;
    tick();
    irqReq = 8'b1000_0001;
    pcIn = 16'h00A5;
    boundary();
    idle(5);
    chk("R3 nested sp", sp, SpInit - 4);
    ret();
    idle(1); boundary(); idle(1);
    irqReq = '0;
    ret();
    idle(2);
    chk("R6 final sp", sp, SpInit);
    chk("R6 gie set after return", gie, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule